// File: doc/BRIEF.md
# DSP-Framed Stereo Serial Receiver

This block takes two-channel PCM audio from a three-wire serial port made of a bit clock, a frame clock and a data line, and returns each frame as a parallel stereo pair. A frame is 64 bit periods long. A single rising frame-clock event opens each frame. In the bit periods that follow, the left word and then the right word arrive with no gap between them, each sent most significant bit first. The remaining slots of the frame are padding and are discarded.

All three serial lines are asynchronous to the system clock. They pass through a shared synchroniser chain. A rising edge of the synchronised bit clock is one bit event, and the frame clock and data line are sampled at that event. A three-state controller follows the frame: ST_HUNT, ST_SHIFT and ST_SKIP. It drives a shift register and a pair of output registers.

The controller's transitions are:
- ST_HUNT goes to ST_SHIFT on the first frame marker after reset.
- ST_SHIFT stays in ST_SHIFT on a marker. This is an early marker, so it flags an error and restarts the count.
- ST_SHIFT goes to ST_SKIP on the last data bit, which loads both words.
- ST_SKIP goes to ST_SHIFT on a marker. It flags an error unless exactly 64 bit events have passed.

Top module: `dsp_serial_rx`

## Requirements
- R1: While rst_n is low, left_sample and right_sample read 0, and sample_valid and frame_err stay low, whatever the serial inputs do.
- R2: A frame marker is a bit event at which the frame clock is sampled high after it was sampled low at the previous bit event. The 16 bit events after the marker carry the left word, MSB first.
- R3: Bit events 17 to 32 after the marker carry the right word, MSB first.
- R4: The data on bit events 33 to 64 after a marker, including the data on the closing marker event itself, has no effect on the captured samples.
- R5: After the 32nd data bit, both words are presented together and sample_valid is high for exactly one system clock. Once per complete frame, the sample outputs change only in a cycle where sample_valid is high.
- R6: A marker that arrives after fewer than 64 bit events gives a one-cycle frame_err pulse and restarts the frame. A frame cut off before its 32nd data bit gives no sample_valid. A frame cut off after its 32nd data bit still delivers its samples.
- R7: A marker that arrives after more than 64 bit events gives a one-cycle frame_err pulse. The frame it opens is decoded normally.
- R8: Bits that arrive after reset but before the first marker give no sample_valid. The first marker after reset raises no frame_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| fclk_in | input | 1 | Serial frame clock, asynchronous |
| sdata_in | input | 1 | Serial data |
| left_sample | output | 16 | Captured left word |
| right_sample | output | 16 | Captured right word |
| sample_valid | output | 1 | One-cycle strobe when a new stereo pair is loaded |
| frame_err | output | 1 | One-cycle pulse on a mistimed frame marker |

## Verification
The bit counter or the controller state can go wrong in several ways, and each one shows at the ports within one frame:
- A slip by one slot shows as a shifted or rotated sample on the next sample_valid, one bit event after the 32nd data bit.
- A wrong state in ST_SKIP shows as padding bits leaking into the right word.
- A missed restart shows as a missing strobe, an extra strobe, or a frame_err pulse at the next marker.

The bench checks frames cut off at 32 and 33 bit events, over-long frames, and all-zero and all-one padding, so that each of these faults leaves a visible trace.

// File: rtl/dsprx_pkg.sv
package dsprx_pkg;

    // Receiver framing states
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,   // waiting for the first marker after reset
        ST_SHIFT = 2'd1,   // collecting left and right data bits
        ST_SKIP  = 2'd2    // discarding padding slots until the next marker
    } rx_state_e;

    // Width of a counter able to reach n (with headroom for saturation)
    function automatic int cnt_width(input int n);
        return $clog2(n) + 1;
    endfunction

endpackage

// File: rtl/dsprx_sync.sv
module dsprx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic         rise0
);

    logic [STAGES-1:0][W-1:0] chain;
    logic                     lvl0_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain  <= '0;
            lvl0_d <= 1'b0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            lvl0_d <= chain[STAGES-1][0];
        end
    end

    assign level = chain[STAGES-1];
    assign rise0 = chain[STAGES-1][0] & ~lvl0_d;

    // R2: a bit event is a single-cycle pulse
    a_r2_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise0 |=> !rise0);

endmodule

// File: rtl/dsprx_ctrl.sv
module dsprx_ctrl
    import dsprx_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int FRAME_SLOTS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_evt,
    input  logic fclk_lvl,
    output logic shift_en,
    output logic load_en,
    output logic err_evt
);

    localparam int DATA_SLOTS = 2 * WORD_W;
    localparam int CNT_W      = cnt_width(FRAME_SLOTS);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_SLOTS - 1);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_SLOTS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             fclk_prev_q;
    logic             marker;

    assign marker = bit_evt & fclk_lvl & ~fclk_prev_q;

    // Frame clock level at the previous bit event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       fclk_prev_q <= 1'b0;
        else if (bit_evt) fclk_prev_q <= fclk_lvl;
    end

    // Bit events since the last marker, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (marker) begin
            cnt_q <= '0;
        end else if (bit_evt && state_q != ST_HUNT && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (marker) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (marker)                            state_d = ST_SHIFT;
                else if (bit_evt && cnt_q == LAST_DATA) state_d = ST_SKIP;
            end
            ST_SKIP:  if (marker) state_d = ST_SHIFT;
            default:  state_d = ST_HUNT;
        endcase
    end

    // Outputs
    always_comb begin
        shift_en = 1'b0;
        load_en  = 1'b0;
        err_evt  = 1'b0;
        unique case (state_q)
            ST_HUNT:  ;
            ST_SHIFT: begin
                if (marker) begin
                    err_evt = 1'b1;
                end else if (bit_evt) begin
                    shift_en = 1'b1;
                    load_en  = (cnt_q == LAST_DATA);
                end
            end
            ST_SKIP:  err_evt = marker && (cnt_q != LAST_SLOT);
            default:  ;
        endcase
    end

    // R2: the data phase never runs past the last data slot
    a_r2_cnt_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (cnt_q <= LAST_DATA));

    // R6: a marker always restarts the frame at slot zero
    a_r6_marker_restart: assert property (@(posedge clk) disable iff (!rst_n)
        marker |=> (state_q == ST_SHIFT) && (cnt_q == '0));

    // R5: loading the pair moves the controller into the padding phase
    a_r5_load_to_skip: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (state_q == ST_SKIP));

    // R8: before the first marker the counter stays idle
    a_r8_hunt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT) |-> (cnt_q == '0));

endmodule

// File: rtl/dsprx_capture.sv
module dsprx_capture #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              load_en,
    input  logic              err_evt,
    input  logic              din,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o,
    output logic              err_o
);

    localparam int PAIR_W = 2 * WORD_W;

    logic [PAIR_W-1:0] shreg_q;
    logic [PAIR_W-1:0] pair_next;

    assign pair_next = {shreg_q[PAIR_W-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        shreg_q <= '0;
        else if (shift_en) shreg_q <= pair_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_o  <= '0;
            right_o <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= load_en;
            err_o   <= err_evt;
            if (load_en) begin
                left_o  <= pair_next[PAIR_W-1:WORD_W];
                right_o <= pair_next[WORD_W-1:0];
            end
        end
    end

    // R5: the strobe lasts one cycle
    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5: samples hold between strobes
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R6: the error pulse lasts one cycle
    a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R6: an error marker and a load never coincide
    a_r6_err_vs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && valid_o));

endmodule

// File: rtl/dsp_serial_rx.sv
module dsp_serial_rx #(
    parameter int WORD_W      = 16,
    parameter int FRAME_SLOTS = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_in,
    input  logic              fclk_in,
    input  logic              sdata_in,
    output logic [WORD_W-1:0] left_sample,
    output logic [WORD_W-1:0] right_sample,
    output logic              sample_valid,
    output logic              frame_err
);

    localparam int LINES = 3;

    generate
        if (FRAME_SLOTS <= 2 * WORD_W) begin : g_bad_frame
            $error("frame must be longer than two words");
        end
        if (SYNC_STAGES < 2) begin : g_bad_sync
            $error("at least two synchroniser stages are needed");
        end
    endgenerate

    logic [LINES-1:0] line_lvl;
    logic             bit_evt;
    logic             shift_en;
    logic             load_en;
    logic             err_evt;

    dsprx_sync #(
        .W      (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sdata_in, fclk_in, bclk_in}),
        .level    (line_lvl),
        .rise0    (bit_evt)
    );

    dsprx_ctrl #(
        .WORD_W      (WORD_W),
        .FRAME_SLOTS (FRAME_SLOTS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_evt  (bit_evt),
        .fclk_lvl (line_lvl[1]),
        .shift_en (shift_en),
        .load_en  (load_en),
        .err_evt  (err_evt)
    );

    dsprx_capture #(
        .WORD_W (WORD_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .load_en  (load_en),
        .err_evt  (err_evt),
        .din      (line_lvl[2]),
        .left_o   (left_sample),
        .right_o  (right_sample),
        .valid_o  (sample_valid),
        .err_o    (frame_err)
    );

endmodule

// File: tb/sim_dsp_serial_rx.sv
module sim_dsp_serial_rx;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        bclk, fclk, sdata;
    logic [15:0] left_s, right_s;
    logic        valid, ferr;

    dsp_serial_rx u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_in      (bclk),
        .fclk_in      (fclk),
        .sdata_in     (sdata),
        .left_sample  (left_s),
        .right_sample (right_s),
        .sample_valid (valid),
        .frame_err    (ferr)
    );

    int n_checks = 0;
    int n_errs   = 0;
    int valid_cnt = 0, err_cnt = 0, wide_cnt = 0, drift_cnt = 0;
    logic [15:0] cap_l = '0, cap_r = '0, prev_l = '0, prev_r = '0;
    logic prev_v = 1'b0, prev_e = 1'b0;
    bit done = 1'b0;

    // Port monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (valid) begin
            valid_cnt++;
            cap_l = left_s;
            cap_r = right_s;
            if (prev_v) wide_cnt++;
        end else if (left_s != prev_l || right_s != prev_r) begin
            drift_cnt++;
        end
        if (ferr) begin
            err_cnt++;
            if (prev_e) wide_cnt++;
        end
        prev_v = valid;
        prev_e = ferr;
        prev_l = left_s;
        prev_r = right_s;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    // Expected serial bit for a given slot after the marker
    function automatic bit slot_bit(input logic [15:0] l, input logic [15:0] r,
                                    input int slot);
        if (slot < 16)      return l[15-slot];
        else if (slot < 32) return r[31-slot];
        return 1'b0;
    endfunction

    task automatic bit_period(input bit f, input bit d);
        fclk  = f;
        sdata = d;
        repeat (4) @(posedge clk);
        #1 bclk = 1'b1;
        repeat (4) @(posedge clk);
        #1 bclk = 1'b0;
    endtask

    // nedges bit events, the first being the marker; padmode 0 random, 1 zeros, 2 ones
    task automatic send_frame(input logic [15:0] l, input logic [15:0] r,
                              input int nedges, input int padmode);
        bit_period(1'b1, 1'($urandom % 2));
        for (int s = 0; s < nedges - 1; s++) begin
            bit d;
            if (s < 32)            d = slot_bit(l, r, s);
            else if (padmode == 1) d = 1'b0;
            else if (padmode == 2) d = 1'b1;
            else                   d = 1'($urandom % 2);
            bit_period(1'b0, d);
        end
        repeat (8) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic good_frame(input logic [15:0] l, input logic [15:0] r,
                              input int padmode, input int exp_err,
                              input string req);
        int v0, e0;
        v0 = valid_cnt;
        e0 = err_cnt;
        send_frame(l, r, 64, padmode);
        check(valid_cnt - v0 == 1, req, "valid count", valid_cnt - v0, 1);
        check(cap_l == l, req, "left word", int'(cap_l), int'(l));
        check(cap_r == r, req, "right word", int'(cap_r), int'(r));
        check(err_cnt - e0 == exp_err, req, "error pulses", err_cnt - e0, exp_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        int v0, e0;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        bclk  = 1'b0;
        fclk  = 1'b0;
        sdata = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(left_s == 0 && right_s == 0, "R1", "samples in reset", int'({left_s, right_s}), 0);
        check(!valid && !ferr, "R1", "flags in reset", int'({valid, ferr}), 0);

        // R1: a full frame while held in reset is ignored
        send_frame(16'hA5C3, 16'h3C5A, 64, 0);
        send_frame(16'h1234, 16'h5678, 64, 0);
        check(valid_cnt == 0 && err_cnt == 0, "R1", "strobes during reset", valid_cnt + err_cnt, 0);
        check(left_s == 0 && right_s == 0, "R1", "samples after reset frames", int'({left_s, right_s}), 0);

        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R8: bits before the first marker
        for (int i = 0; i < 40; i++) bit_period(1'b0, 1'($urandom % 2));
        repeat (8) @(negedge clk);
        check(valid_cnt == 0, "R8", "valid before marker", valid_cnt, 0);

        // R8, R2, R3: first frame, no error, MSB-first order
        good_frame(16'h8000, 16'h0001, 0, 0, "R8");
        good_frame(16'h0001, 16'h8000, 0, 0, "R2");
        good_frame(16'hFFFF, 16'h0000, 2, 0, "R3");
        // R4: padding of all ones / all zeros does not leak
        good_frame(16'h0000, 16'h0000, 2, 0, "R4");
        good_frame(16'hFFFF, 16'hFFFF, 1, 0, "R4");

        // R4, R5: random frames with random padding
        for (int i = 0; i < 12; i++) begin
            good_frame(16'($urandom), 16'($urandom), 0, 0, "R5");
        end

        // R6: cut off before the 32nd data bit (marker + 31 data slots)
        v0 = valid_cnt; e0 = err_cnt;
        send_frame(16'hDEAD, 16'hBEEF, 32, 0);
        check(valid_cnt == v0, "R6", "valid from 31-slot frame", valid_cnt - v0, 0);
        good_frame(16'h1357, 16'h2468, 0, 1, "R6");

        // R6: cut off just after the 32nd data bit still delivers
        v0 = valid_cnt;
        send_frame(16'hCAFE, 16'hF00D, 33, 1);
        check(valid_cnt - v0 == 1, "R6", "valid from 32-slot frame", valid_cnt - v0, 1);
        check(cap_l == 16'hCAFE && cap_r == 16'hF00D, "R6", "samples of 32-slot frame",
              int'({cap_l, cap_r}), 32'hCAFEF00D);
        good_frame(16'h0F0F, 16'hF0F0, 0, 1, "R6");

        // R6: very short frame
        v0 = valid_cnt;
        send_frame(16'h7777, 16'h8888, 5, 0);
        check(valid_cnt == v0, "R6", "valid from 4-slot frame", valid_cnt - v0, 0);
        good_frame(16'h4242, 16'h2424, 0, 1, "R6");

        // R7: over-long frame, then a normal frame
        v0 = valid_cnt;
        send_frame(16'h9ABC, 16'hDEF0, 70, 0);
        check(valid_cnt - v0 == 1, "R7", "valid from long frame", valid_cnt - v0, 1);
        check(cap_l == 16'h9ABC && cap_r == 16'hDEF0, "R7", "samples of long frame",
              int'({cap_l, cap_r}), 32'h9ABCDEF0);
        good_frame(16'h5555, 16'hAAAA, 0, 1, "R7");
        good_frame(16'h3C3C, 16'hC3C3, 0, 0, "R7");

        // R5: strobes one cycle wide, no output change without a strobe
        check(wide_cnt == 0, "R5", "wide strobes", wide_cnt, 0);
        check(drift_cnt == 0, "R5", "output changes without strobe", drift_cnt, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule